// File: doc/BRIEF.md
# DCO Mode Controller with Delayed Holdover History

This block chooses the operating mode of a digital PLL and drives the frequency word of its digitally controlled oscillator. The three modes are free-running, locked (normal) and holdover. In normal mode the loop filter's word passes straight through to the oscillator. The block also samples that word at fixed millisecond intervals into a small circular history. In holdover the oscillator word is frozen. In free-running mode the oscillator gets a fixed nominal word, so its accuracy then depends only on the master oscillator.

The frozen holdover word is not the most recent sample. It is the sample written one slot before the newest, so its age lies between one and two slot intervals; with the default 26 ms slot that is 26 to 52 ms. A reference that is drifting just before it is declared failed therefore cannot corrupt the held frequency. Mode is set by a two-bit mode select, a reference select with per-reference fail flags, and a manual holdover request. A one-cycle millisecond tick paces the sampling.

Top module: `dco_mode_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, the mode is free-running (encoding 0; normal is 1, holdover is 2, and 3 never appears). The oscillator word is NOMINAL_WORD, and the history holds no valid samples.
- R2: Mode select 0 forces free-running mode one clock later. While free-running, the oscillator word equals NOMINAL_WORD.
- R3: In normal mode the oscillator word equals the loop word in the same cycle, with no register in the path.
- R4: Mode select 3 is automatic control. From free-running or holdover, the mode becomes normal one clock later when the fail flag of the selected reference is low and the manual request is low. The selected flag is ref_fail bit ref_sel.
- R5: Under automatic control in normal mode, a high selected fail flag or a high manual request moves the mode to holdover one clock later. A fail flag on the unselected reference has no effect.
- R6: Mode select 1 is manual normal. The mode is normal unless the manual request is high, in which case it is holdover. Fail flags are ignored.
- R7: Mode select 2 forces holdover one clock later from any mode.
- R8: In normal mode, every SLOT_MS-th millisecond tick writes the loop word into the next history slot. In other modes the tick counter and the history are frozen.
- R9: On holdover entry the word is latched from the history sample one slot older than the newest. It stays constant for as long as holdover lasts.
- R10: If holdover is entered with fewer than TAP_AGE+1 valid samples (two by default), the held word is NOMINAL_WORD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | 0 free-run, 1 manual normal, 2 forced holdover, 3 automatic |
| ref_sel | input | 1 | Selects which reference's fail flag applies |
| ref_fail | input | 2 | Fail flag per reference |
| hold_req | input | 1 | Manual holdover request |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| loop_fw | input | FW | Loop filter frequency word |
| mode | output | 2 | Current mode (0 free-run, 1 normal, 2 holdover) |
| dco_fw | output | FW | Frequency word to the oscillator |

## Verification
The bench builds the block with a four-tick slot, a 16-bit word and a nominal word of 0x8000. Every history write and the wrap of the three-slot ring therefore occur within a few dozen cycles. With these values the vectors can check which slot holdover latches after the ring has wrapped, and that ticks arriving during holdover leave both the partially counted slot and the stored samples untouched. They also cover the fallback to the nominal word after only one sample has been stored since reset.

// File: rtl/dco_mode_pkg.sv
`timescale 1ns/1ps
package dco_mode_pkg;
   typedef enum logic [1:0] {
      MODE_FREERUN  = 2'd0,
      MODE_NORMAL   = 2'd1,
      MODE_HOLDOVER = 2'd2
   } dco_mode_e;

   localparam logic [1:0] SEL_FREERUN = 2'd0;
   localparam logic [1:0] SEL_MANUAL  = 2'd1;
   localparam logic [1:0] SEL_HOLD    = 2'd2;
   localparam logic [1:0] SEL_AUTO    = 2'd3;
endpackage

// File: rtl/dco_mode_fsm.sv
`timescale 1ns/1ps
module dco_mode_fsm
   import dco_mode_pkg::*;
#(
   parameter int NUM_REFS = 2,
   localparam int RSW = (NUM_REFS > 1) ? $clog2(NUM_REFS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          mode_sel,
   input  logic [RSW-1:0]      ref_sel,
   input  logic [NUM_REFS-1:0] ref_fail,
   input  logic                hold_req,
   output dco_mode_e           mode_q,
   output logic                enter_hold
);
   dco_mode_e mode_d;
   logic      sel_fail;

   always_comb begin
      sel_fail = 1'b0;
      for (int i = 0; i < NUM_REFS; i++) begin
         if (RSW'(i) == ref_sel) sel_fail = ref_fail[i];
      end
   end

   always_comb begin
      mode_d = mode_q;
      unique case (mode_sel)
         SEL_FREERUN: mode_d = MODE_FREERUN;
         SEL_HOLD:    mode_d = MODE_HOLDOVER;
         SEL_MANUAL:  mode_d = hold_req ? MODE_HOLDOVER : MODE_NORMAL;
         SEL_AUTO: begin
            if (!sel_fail && !hold_req)       mode_d = MODE_NORMAL;
            else if (mode_q == MODE_NORMAL)   mode_d = MODE_HOLDOVER;
            else                              mode_d = mode_q;
         end
         default:     mode_d = MODE_FREERUN;
      endcase
   end

   assign enter_hold = (mode_d == MODE_HOLDOVER) && (mode_q != MODE_HOLDOVER);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_FREERUN;
      else        mode_q <= mode_d;
   end
endmodule

// File: rtl/dco_slot_timer.sv
`timescale 1ns/1ps
module dco_slot_timer #(
   parameter int SLOT_MS = 26
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic ms_tick,
   output logic store_stb
);
   generate
      if (SLOT_MS == 1) begin : g_every_tick
         assign store_stb = run & ms_tick;
      end else begin : g_counted
         localparam int CW = $clog2(SLOT_MS);
         localparam logic [CW-1:0] LAST = CW'(SLOT_MS - 1);
         logic [CW-1:0] cnt_q;

         assign store_stb = run && ms_tick && (cnt_q == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (run && ms_tick) begin
               if (cnt_q == LAST) cnt_q <= '0;
               else               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/dco_hist_buf.sv
`timescale 1ns/1ps
module dco_hist_buf #(
   parameter int FW      = 32,
   parameter int DEPTH   = 3,
   parameter int TAP_AGE = 1,
   localparam int PW     = $clog2(DEPTH),
   localparam int NW     = $clog2(DEPTH + 1),
   localparam int OFFS   = DEPTH - 1 - TAP_AGE
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [FW-1:0] wr_data,
   output logic [FW-1:0] tap_data,
   output logic          tap_valid
);
   logic [FW-1:0] slot_q [DEPTH];
   logic [PW-1:0] wr_ptr_q;
   logic [NW-1:0] fill_q;
   logic [PW-1:0] tap_idx;

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              slot_q[s] <= '0;
         else if (wr_en && wr_ptr_q == PW'(s))    slot_q[s] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         fill_q   <= '0;
      end else if (wr_en) begin
         wr_ptr_q <= (wr_ptr_q == PW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
         if (fill_q != NW'(DEPTH)) fill_q <= fill_q + 1'b1;
      end
   end

   always_comb begin
      int sum;
      sum = int'(wr_ptr_q) + OFFS;
      if (sum >= DEPTH) sum = sum - DEPTH;
      tap_idx = PW'(sum);
   end

   assign tap_data  = slot_q[tap_idx];
   assign tap_valid = (fill_q > NW'(TAP_AGE));
endmodule

// File: rtl/dco_mode_ctrl.sv
`timescale 1ns/1ps
module dco_mode_ctrl
   import dco_mode_pkg::*;
#(
   parameter int          FW           = 32,
   parameter int          SLOT_MS      = 26,
   parameter int          HIST_DEPTH   = 3,
   parameter int          TAP_AGE      = 1,
   parameter logic [FW-1:0] NOMINAL_WORD = FW'(1) << (FW - 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    mode_sel,
   input  logic          ref_sel,
   input  logic [1:0]    ref_fail,
   input  logic          hold_req,
   input  logic          ms_tick,
   input  logic [FW-1:0] loop_fw,
   output logic [1:0]    mode,
   output logic [FW-1:0] dco_fw
);
   if (FW < 2)                     begin : g_bad_fw    $error("FW must be at least 2"); end
   if (SLOT_MS < 1)                begin : g_bad_slot  $error("SLOT_MS must be positive"); end
   if (HIST_DEPTH < 2)             begin : g_bad_depth $error("HIST_DEPTH must be at least 2"); end
   if (TAP_AGE < 0 || TAP_AGE >= HIST_DEPTH)
                                   begin : g_bad_tap   $error("TAP_AGE out of range"); end

   dco_mode_e     mode_q;
   logic          enter_hold;
   logic          store_stb;
   logic [FW-1:0] tap_data;
   logic          tap_valid;
   logic [FW-1:0] held_q;

   dco_mode_fsm #(.NUM_REFS(2)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_sel   (mode_sel),
      .ref_sel    (ref_sel),
      .ref_fail   (ref_fail),
      .hold_req   (hold_req),
      .mode_q     (mode_q),
      .enter_hold (enter_hold)
   );

   dco_slot_timer #(.SLOT_MS(SLOT_MS)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (mode_q == MODE_NORMAL),
      .ms_tick   (ms_tick),
      .store_stb (store_stb)
   );

   dco_hist_buf #(.FW(FW), .DEPTH(HIST_DEPTH), .TAP_AGE(TAP_AGE)) u_hist (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (store_stb),
      .wr_data   (loop_fw),
      .tap_data  (tap_data),
      .tap_valid (tap_valid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          held_q <= NOMINAL_WORD;
      else if (enter_hold) held_q <= tap_valid ? tap_data : NOMINAL_WORD;
   end

   always_comb begin
      unique case (mode_q)
         MODE_NORMAL:   dco_fw = loop_fw;
         MODE_HOLDOVER: dco_fw = held_q;
         default:       dco_fw = NOMINAL_WORD;
      endcase
   end

   assign mode = mode_q;
endmodule

// File: rtl/dco_mode_ctrl_chk.sv
`timescale 1ns/1ps
module dco_mode_ctrl_chk #(
   parameter int            FW           = 32,
   parameter logic [FW-1:0] NOMINAL_WORD = '0
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    mode_sel,
   input logic          ref_sel,
   input logic [1:0]    ref_fail,
   input logic          hold_req,
   input logic [FW-1:0] loop_fw,
   input logic [1:0]    mode,
   input logic [FW-1:0] dco_fw
);
   assert_mode_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mode != 2'd3);

   assert_freerun_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mode_sel == 2'd0 |=> mode == 2'd0);

   assert_freerun_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mode == 2'd0 |-> dco_fw == NOMINAL_WORD);

   assert_normal_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mode == 2'd1 |-> dco_fw == loop_fw);

   assert_auto_to_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == 2'd3 && mode == 2'd1 && (ref_fail[ref_sel] || hold_req)) |=> mode == 2'd2);

   assert_manual_normal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == 2'd1 && !hold_req) |=> mode == 2'd1);

   assert_forced_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mode_sel == 2'd2 |=> mode == 2'd2);

   assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd2 && $past(mode) == 2'd2) |-> $stable(dco_fw));
endmodule

bind dco_mode_ctrl dco_mode_ctrl_chk #(.FW(FW), .NOMINAL_WORD(NOMINAL_WORD)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode_sel (mode_sel),
   .ref_sel  (ref_sel),
   .ref_fail (ref_fail),
   .hold_req (hold_req),
   .loop_fw  (loop_fw),
   .mode     (mode),
   .dco_fw   (dco_fw)
);

// File: tb/test_dco_mode_ctrl.sv
`timescale 1ns/1ps
module test_dco_mode_ctrl;
   localparam int          FW  = 16;
   localparam logic [15:0] NOM = 16'h8000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode_sel = 2'd0;
   logic        ref_sel = 1'b0;
   logic [1:0]  ref_fail = 2'b00;
   logic        hold_req = 1'b0;
   logic        ms_tick = 1'b0;
   logic [15:0] loop_fw = 16'h0;
   logic [1:0]  mode;
   logic [15:0] dco_fw;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   dco_mode_ctrl #(.FW(FW), .SLOT_MS(4), .HIST_DEPTH(3), .TAP_AGE(1), .NOMINAL_WORD(NOM)) i_dco_mode_ctrl (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ref_sel(ref_sel), .ref_fail(ref_fail),
      .hold_req(hold_req), .ms_tick(ms_tick), .loop_fw(loop_fw), .mode(mode), .dco_fw(dco_fw)
   );

   // fields: req(4) sel(2) rsel(1) fail(2) hold(1) ticks(4) loop(16) exp_mode(2) exp_fw(16)
   localparam int NV = 12;
   localparam logic [47:0] VEC [NV] = '{
      {4'd4,  2'd3, 1'b0, 2'b00, 1'b0, 4'd0, 16'h1111, 2'd1, 16'h1111}, // R4 free-run to normal
      {4'd8,  2'd3, 1'b0, 2'b00, 1'b0, 4'd4, 16'h0A0A, 2'd1, 16'h0A0A}, // R8 first sample stored
      {4'd6,  2'd1, 1'b0, 2'b01, 1'b0, 4'd4, 16'h0B0B, 2'd1, 16'h0B0B}, // R6 fail ignored, sample 2
      {4'd5,  2'd3, 1'b1, 2'b01, 1'b0, 4'd3, 16'h0C0C, 2'd1, 16'h0C0C}, // R5 unselected fail ignored
      {4'd9,  2'd3, 1'b0, 2'b01, 1'b0, 4'd0, 16'h0D0D, 2'd2, 16'h0A0A}, // R9 one slot older than newest
      {4'd8,  2'd3, 1'b0, 2'b01, 1'b0, 4'd8, 16'h0E0E, 2'd2, 16'h0A0A}, // R8 ticks in holdover frozen
      {4'd4,  2'd3, 1'b0, 2'b00, 1'b0, 4'd0, 16'h0E0E, 2'd1, 16'h0E0E}, // R4 holdover to normal
      {4'd8,  2'd3, 1'b0, 2'b00, 1'b0, 4'd1, 16'h0F0F, 2'd1, 16'h0F0F}, // R8 partial count resumed
      {4'd5,  2'd3, 1'b0, 2'b00, 1'b1, 4'd0, 16'h0123, 2'd2, 16'h0B0B}, // R5 manual request, ring wrapped
      {4'd7,  2'd2, 1'b0, 2'b00, 1'b0, 4'd0, 16'h0456, 2'd2, 16'h0B0B}, // R7 forced hold keeps word
      {4'd2,  2'd0, 1'b0, 2'b00, 1'b0, 4'd2, 16'h0789, 2'd0, 16'h8000}, // R2 forced free-run
      {4'd7,  2'd2, 1'b0, 2'b11, 1'b0, 4'd0, 16'h0ABC, 2'd2, 16'h0B0B}  // R7 hold from free-run
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      mode_sel = 2'd0; ref_sel = 1'b0; ref_fail = 2'b00; hold_req = 1'b0; ms_tick = 1'b0; loop_fw = 16'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic pulse_ticks(input int n);
      for (int k = 0; k < n; k++) begin
         ms_tick = 1'b1;
         @(negedge clk);
      end
      ms_tick = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      do_reset();
      check("R1 mode after reset", 32'(mode), 32'd0);
      check("R1 word after reset", 32'(dco_fw), 32'(NOM));

      for (int v = 0; v < NV; v++) begin
         mode_sel = VEC[v][43:42];
         ref_sel  = VEC[v][41];
         ref_fail = VEC[v][40:39];
         hold_req = VEC[v][38];
         loop_fw  = VEC[v][33:18];
         pulse_ticks(int'(VEC[v][37:34]));
         check($sformatf("R%0d vector %0d mode", VEC[v][47:44], v), 32'(mode), 32'(VEC[v][17:16]));
         check($sformatf("R%0d vector %0d word", VEC[v][47:44], v), 32'(dco_fw), 32'(VEC[v][15:0]));
      end

      // R10: only one sample stored since reset, holdover falls back to nominal
      do_reset();
      mode_sel = 2'd3;
      loop_fw = 16'h1234;
      @(negedge clk);
      check("R4 normal after reset", 32'(mode), 32'd1);
      // R3: loop word reaches output without a clock edge
      loop_fw = 16'h5555;
      #1;
      check("R3 same-cycle passthrough", 32'(dco_fw), 32'h5555);
      loop_fw = 16'h1234;
      pulse_ticks(4);
      hold_req = 1'b1;
      @(negedge clk);
      check("R10 mode holdover", 32'(mode), 32'd2);
      check("R10 nominal fallback", 32'(dco_fw), 32'(NOM));
      loop_fw = 16'h4321;
      pulse_ticks(2);
      check("R9 word constant in holdover", 32'(dco_fw), 32'(NOM));

      // R1: reset mid-holdover returns to free-run and invalidates history
      rst_n = 1'b0;
      #1;
      check("R1 mode during reset", 32'(mode), 32'd0);
      check("R1 word during reset", 32'(dco_fw), 32'(NOM));
      finish_run();
   end
endmodule